// File: doc/BRIEF.md
# Multicore Preemptive Sleep Scheduler

This controller decides, one clock at a time, whether a multicore server executes or naps. Each core slot has an occupancy flag and a stall counter. The counter accumulates how long the request held in that slot has been held back. Execution is allowed only when every slot holds a request. As soon as a completion leaves a slot empty, all work is preempted and the server is asked to sleep. The only exception is a request whose accumulated stall has reached a programmable ceiling. Such a request forces execution on all cores until that particular request completes. This bounds the extra latency any one request can suffer, and no batching timeout is involved.

Request dispatch and the power-state hardware sit outside the block. Dispatch reports an arriving request with `arr_valid` and per-core completions with `done_vec`. The power side is told what to do through `exec_en`, with one-cycle `sleep_req` and `wake_req` pulses on each change of state. `tick_en` sets the time base of the stall counters.

Top module: `nap_weave_sched`

## Requirements
- R1: While `rst_n` is low and right after it is released, `slot_busy` is all zero and `exec_en`, `forced_run`, `sleep_req` and `wake_req` are low.
- R2: `arr_valid` places a new request in the lowest-numbered slot that was free at the start of the cycle, and `slot_busy` shows it after the next rising edge. When all slots are busy the arrival is dropped and `slot_busy` is unchanged.
- R3: In the cycle after every slot becomes occupied, `exec_en` is high and `forced_run` is low. `exec_en` never reports normal execution with a free slot.
- R4: A completion on an occupied slot while executing frees that slot. If no held request has reached the ceiling, the next cycle shows `exec_en` low and a single-cycle `sleep_req`.
- R5: A `done_vec` bit for a free slot, or any completion while stalled, is ignored and `slot_busy` does not change.
- R6: A request's stall count starts at zero when the request is placed. It rises by one on each cycle in which the block is stalled and `tick_en` is high, and it keeps its value while executing and across later stall episodes. It saturates at 2^CNT_W-1, so a ceiling of 65535 is reached after exactly 65535 counted cycles.
- R7: When a held request's count reaches `stall_limit` while not all slots are busy, the next cycle shows `exec_en` and `forced_run` high. `forced_slot` then names the lowest-numbered slot that reached the ceiling.
- R8: Forced execution persists while free slots stay free and other completions occur. It ends only when the slot named by `forced_slot` completes, after which the block stalls or forces again for another expired request.
- R9: When a completion and a ceiling hit occur in the same cycle, the block enters forced execution instead of sleeping, and no `sleep_req` is issued.
- R10: An arrival during forced execution fills a free slot. If that makes every slot busy, the next cycle shows normal execution with `forced_run` low.
- R11: With `stall_limit` at zero the block executes whenever any request is present and stalls only when every slot is empty.
- R12: `wake_req` is a single-cycle pulse in the first cycle of execution after a stall. It never coincides with `sleep_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Stall-time base; counters advance only when high |
| stall_limit | input | CNT_W | Stall ceiling per request |
| arr_valid | input | 1 | A new single-core request arrives |
| done_vec | input | NUM_CORES | Per-core request completion |
| slot_busy | output | NUM_CORES | Occupancy of each core slot |
| exec_en | output | 1 | Cores may execute (high) or are preempted and napping (low) |
| forced_run | output | 1 | Execution is forced by an expired request |
| forced_slot | output | IDX_W | Slot whose completion ends forced execution |
| sleep_req | output | 1 | Pulse on entry to the stall state |
| wake_req | output | 1 | Pulse on leaving the stall state |

## Verification
A corrupted occupancy vector appears on `slot_busy` in the cycle after the fault. It also shifts the next decision: execution with a free slot, or a missed full-occupancy start. A stall counter that advances at the wrong time or fails to clear leaves no immediate trace, because it only moves the cycle in which forced execution begins. The bench therefore times the forced entry to the exact cycle for several ceilings, including zero and the saturation value. Wrong priority between a completion and a ceiling hit shows within one cycle as a stray `sleep_req`.

// File: rtl/nap_sched_pkg.sv
package nap_sched_pkg;
  typedef enum logic [1:0] {
    MODE_STALL  = 2'd0,
    MODE_RUN    = 2'd1,
    MODE_FORCED = 2'd2
  } sched_mode_e;
endpackage

// File: rtl/lowest_set.sv
// Finds the lowest-numbered set bit of a vector.
module lowest_set #(
  parameter int N    = 4,
  parameter int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/stall_ctr.sv
// Saturating stall-time counter for one core slot.
module stall_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nx
);
  always_comb begin
    cnt_nx = cnt_q;
    if (clr)
      cnt_nx = '0;
    else if (adv && (cnt_q != {W{1'b1}}))
      cnt_nx = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  // R6: the count only ever restarts at zero or moves up by one
  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> ((cnt_q == '0) || (cnt_q == $past(cnt_q) + 1'b1)));
endmodule

// File: rtl/mode_fsm.sv
// Run / stall / forced-run decision and the transition pulses.
module mode_fsm
  import nap_sched_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  occ_nx,
  input  logic          hit_any,
  input  logic [IW-1:0] hit_idx,
  output sched_mode_e   mode_q,
  output logic [IW-1:0] trk_q,
  output logic          sleep_q,
  output logic          wake_q
);
  sched_mode_e   mode_nx;
  logic [IW-1:0] trk_nx;
  logic          trk_alive;

  always_comb begin
    trk_alive = occ_nx[trk_q];
    mode_nx   = MODE_STALL;
    trk_nx    = trk_q;
    if (&occ_nx) begin
      mode_nx = MODE_RUN;
    end else if ((mode_q == MODE_FORCED) && trk_alive) begin
      mode_nx = MODE_FORCED;
    end else if (hit_any) begin
      mode_nx = MODE_FORCED;
      trk_nx  = hit_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_STALL;
      trk_q   <= '0;
      sleep_q <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      mode_q  <= mode_nx;
      trk_q   <= trk_nx;
      sleep_q <= (mode_q != MODE_STALL) && (mode_nx == MODE_STALL);
      wake_q  <= (mode_q == MODE_STALL) && (mode_nx != MODE_STALL);
    end
  end

  // R12: transition pulses are exclusive
  assert_pulse_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleep_q && wake_q));
  // R12: a wake pulse always coincides with execution
  assert_wake_runs_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> (mode_q != MODE_STALL));
  // R4: a sleep pulse always coincides with the stall state
  assert_sleep_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_q |-> (mode_q == MODE_STALL));
endmodule

// File: rtl/nap_weave_sched.sv
module nap_weave_sched
  import nap_sched_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CNT_W     = 16,
  localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic [CNT_W-1:0]     stall_limit,
  input  logic                 arr_valid,
  input  logic [NUM_CORES-1:0] done_vec,
  output logic [NUM_CORES-1:0] slot_busy,
  output logic                 exec_en,
  output logic                 forced_run,
  output logic [IDX_W-1:0]     forced_slot,
  output logic                 sleep_req,
  output logic                 wake_req
);
  sched_mode_e          mode_q;
  logic [IDX_W-1:0]     trk_q;
  logic [NUM_CORES-1:0] occ_q, occ_nx;
  logic [NUM_CORES-1:0] done_eff, alloc_oh, adv_vec, hit_vec;
  logic                 free_found, hit_any, running;
  logic [IDX_W-1:0]     free_idx, hit_idx;
  logic [CNT_W-1:0]     cnt_q  [NUM_CORES];
  logic [CNT_W-1:0]     cnt_nx [NUM_CORES];

  assign running = (mode_q != MODE_STALL);

  lowest_set #(.N(NUM_CORES), .IW(IDX_W)) u_free (
    .vec(~occ_q), .found(free_found), .idx(free_idx));

  always_comb begin
    done_eff = running ? (done_vec & occ_q) : '0;
    alloc_oh = (arr_valid && free_found) ? (NUM_CORES'(1) << free_idx) : '0;
    occ_nx   = (occ_q & ~done_eff) | alloc_oh;
    adv_vec  = (!running && tick_en) ? occ_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_nx;
  end

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_slot
    stall_ctr #(.W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .clr(alloc_oh[g]), .adv(adv_vec[g]),
      .cnt_q(cnt_q[g]), .cnt_nx(cnt_nx[g]));
    assign hit_vec[g] = occ_nx[g] && (cnt_nx[g] >= stall_limit);
  end

  lowest_set #(.N(NUM_CORES), .IW(IDX_W)) u_hit (
    .vec(hit_vec), .found(hit_any), .idx(hit_idx));

  mode_fsm #(.N(NUM_CORES), .IW(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .occ_nx(occ_nx), .hit_any(hit_any),
    .hit_idx(hit_idx), .mode_q(mode_q), .trk_q(trk_q),
    .sleep_q(sleep_req), .wake_q(wake_req));

  assign slot_busy   = occ_q;
  assign exec_en     = running;
  assign forced_run  = (mode_q == MODE_FORCED);
  assign forced_slot = trk_q;

  // R3: normal execution only with every slot occupied
  assert_run_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RUN) |-> (&occ_q));
  // R3: a fully occupied machine never stays stalled
  assert_full_not_stalled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_STALL) |-> !(&occ_q));
  // R8: the tracked slot is held for the whole forced episode
  assert_tracked_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_FORCED) |-> occ_q[trk_q]);
  // R5: completions are ignored while stalled
  assert_stall_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_STALL) && !arr_valid) |=> (occ_q == $past(occ_q)));
endmodule

// File: tb/tb_nap_weave_sched.sv
module tb_nap_weave_sched;
  localparam int NC = 4;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tick_en;
  logic [CW-1:0] stall_limit;
  logic          arr_valid;
  logic [NC-1:0] done_vec;
  logic [NC-1:0] slot_busy;
  logic          exec_en, forced_run, sleep_req, wake_req;
  logic [1:0]    forced_slot;

  int n_chk = 0;
  int n_bad = 0;

  // reference state derived from the requirements (0 stall, 1 run, 2 forced)
  logic [NC-1:0] m_occ;
  int m_cnt [NC];
  int m_mode, m_trk;
  bit m_slp, m_wk;

  always #5 clk = ~clk;

  nap_weave_sched #(.NUM_CORES(NC), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .stall_limit(stall_limit),
    .arr_valid(arr_valid), .done_vec(done_vec), .slot_busy(slot_busy),
    .exec_en(exec_en), .forced_run(forced_run), .forced_slot(forced_slot),
    .sleep_req(sleep_req), .wake_req(wake_req));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_occ = '0; m_mode = 0; m_trk = 0; m_slp = 0; m_wk = 0;
    for (int i = 0; i < NC; i++) m_cnt[i] = 0;
  endtask

  task automatic model_step(input bit a, input logic [NC-1:0] d, input bit t);
    logic [NC-1:0] de, on;
    int al, hit, mn, lim;
    int cn [NC];
    lim = int'(stall_limit);
    de  = (m_mode != 0) ? (d & m_occ) : '0;
    al  = -1;
    for (int i = 0; i < NC; i++) if (!m_occ[i] && al < 0) al = i;
    if (!a) al = -1;
    on = m_occ & ~de;
    if (al >= 0) on[al] = 1'b1;
    hit = -1;
    for (int i = 0; i < NC; i++) begin
      if (i == al) cn[i] = 0;
      else if (m_mode == 0 && t && m_occ[i] && m_cnt[i] < 65535) cn[i] = m_cnt[i] + 1;
      else cn[i] = m_cnt[i];
      if (on[i] && cn[i] >= lim && hit < 0) hit = i;
    end
    if (on == '1) mn = 1;
    else if (m_mode == 2 && on[m_trk]) mn = 2;
    else if (hit >= 0) begin mn = 2; m_trk = hit; end
    else mn = 0;
    m_slp = (m_mode != 0) && (mn == 0);
    m_wk  = (m_mode == 0) && (mn != 0);
    m_mode = mn;
    m_occ  = on;
    for (int i = 0; i < NC; i++) m_cnt[i] = cn[i];
  endtask

  task automatic compare_all();
    chk("R2 slot_busy", int'(slot_busy), int'(m_occ));
    chk("R3 exec_en", int'(exec_en), int'(m_mode != 0));
    chk("R7 forced_run", int'(forced_run), int'(m_mode == 2));
    if (m_mode == 2) chk("R8 forced_slot", int'(forced_slot), m_trk);
    chk("R4 sleep_req", int'(sleep_req), int'(m_slp));
    chk("R12 wake_req", int'(wake_req), int'(m_wk));
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input bit a, input logic [NC-1:0] d, input bit t);
    arr_valid = a; done_vec = d; tick_en = t;
    model_step(a, d, t);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input int lim);
    rst_n = 1'b0; arr_valid = 0; done_vec = '0; tick_en = 0;
    stall_limit = CW'(lim);
    model_reset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; arr_valid = 0; done_vec = '0; tick_en = 0; stall_limit = '0;
    @(negedge clk);
    chk("R1 busy in reset", int'(slot_busy), 0);
    do_reset(3);
    chk("R1 busy", int'(slot_busy), 0);
    chk("R1 exec", int'(exec_en), 0);
    chk("R1 forced", int'(forced_run), 0);
    chk("R1 pulses", int'(sleep_req | wake_req), 0);

    // ceiling 3: lone request is forced after exactly three counted cycles
    step(1, 4'b0000, 1);
    chk("R2 first slot", int'(slot_busy), 1);
    chk("R6 not yet", int'(forced_run), 0);
    step(0, 4'b0000, 1);
    step(0, 4'b0000, 1);
    chk("R6 two ticks", int'(forced_run), 0);
    step(0, 4'b0000, 1);
    chk("R7 forced", int'(forced_run), 1);
    chk("R7 forced slot", int'(forced_slot), 0);
    chk("R12 wake pulse", int'(wake_req), 1);
    step(0, 4'b0010, 0);
    chk("R5 free done ignored", int'(slot_busy), 1);
    chk("R8 still forced", int'(forced_run), 1);
    chk("R12 pulse single", int'(wake_req), 0);
    step(1, 4'b0000, 1);
    chk("R8 free slots idle", int'(slot_busy), 3);
    chk("R8 forced on", int'(forced_run), 1);
    step(0, 4'b0001, 1);
    chk("R4 stalled", int'(exec_en), 0);
    chk("R4 sleep pulse", int'(sleep_req), 1);
    chk("R8 busy", int'(slot_busy), 2);
    step(0, 4'b0010, 0);
    chk("R5 done in stall", int'(slot_busy), 2);
    step(0, 4'b0000, 0);
    step(0, 4'b0000, 1);
    step(0, 4'b0000, 1);
    chk("R6 gated by tick", int'(forced_run), 0);
    step(0, 4'b0000, 1);
    chk("R7 slot one", int'(forced_slot), 1);
    chk("R7 forced again", int'(forced_run), 1);
    step(1, 4'b0000, 0);
    step(1, 4'b0000, 0);
    chk("R10 forced partial", int'(forced_run), 1);
    step(1, 4'b0000, 0);
    chk("R10 full run", int'(exec_en), 1);
    chk("R10 not forced", int'(forced_run), 0);
    step(1, 4'b0000, 0);
    chk("R2 full drop", int'(slot_busy), 15);
    step(0, 4'b0001, 0);
    chk("R9 hit beats completion", int'(forced_run), 1);
    chk("R9 tracked", int'(forced_slot), 1);
    chk("R9 no sleep", int'(sleep_req), 0);
    chk("R9 busy", int'(slot_busy), 14);

    // zero ceiling: run whenever anything is present
    do_reset(0);
    step(1, 4'b0000, 0);
    chk("R11 runs at once", int'(exec_en), 1);
    chk("R11 forced", int'(forced_run), 1);
    step(0, 4'b0001, 0);
    chk("R11 empty sleeps", int'(exec_en), 0);
    chk("R11 sleep pulse", int'(sleep_req), 1);

    // sweep over small ceilings with pseudo-random traffic
    for (int lim = 0; lim < 7; lim++) begin
      do_reset(lim);
      for (int c = 0; c < 2500; c++) begin
        logic [NC-1:0] d;
        for (int i = 0; i < NC; i++) d[i] = (($urandom % 7) == 0);
        step((($urandom % 10) < 3), d, (($urandom % 10) < 7));
        compare_all();
      end
    end

    // saturation: the full-scale ceiling is reached after 65535 ticks
    do_reset(65535);
    step(1, 4'b0000, 1);
    for (int c = 0; c < 65534; c++) step(0, 4'b0000, 1);
    chk("R6 before max", int'(forced_run), 0);
    step(0, 4'b0000, 1);
    chk("R6 at max", int'(forced_run), 1);
    step(0, 4'b0000, 1);
    chk("R6 saturated hold", int'(forced_run), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule